// File: doc/BRIEF.md
# Three-Level Interrupt Priority Arbiter

The arbiter gathers thirteen interrupt requests and tells the processor which one to take next. Six requests come from external pins, which are synchronized, edge-detected and latched into sticky pending flags. Six come from level-sensitive internal flags, one of which is the watchdog flag. The last is a power-fail request. Every maskable source has an enable bit and a high/low priority bit, and a global enable gates all of them. The power-fail request has only its own enable, and it always ranks above both user levels.

The block presents a source index on `irq_vec` and asserts `irq_valid` while an eligible request exists. The processor returns a one-cycle `ack` when it takes the interrupt. The arbiter then marks that priority level as in service and clears the pending flag of an edge-triggered source. A one-cycle `reti` pulse ends the service at the highest level in service. A request is eligible only if its level is above every level already in service, so a low-level handler can be interrupted by a high or power-fail request, and no handler is interrupted from its own level or a lower one.

Source indices, where a lower index wins within a level: 0 is power-fail, 1 to 6 are external pins 0 to 5, and 7 to 12 are internal flags 0 to 5. Internal flag 5 is the watchdog. Bit j of `src_en` and `src_hi` belongs to source j+1.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_valid` is 0, all three in-service outputs are 0 and `ext_pend` is 0.
- R2: External pins 2 and 4 detect a rising (0 to 1) edge, and pins 0, 1, 3 and 5 detect a falling (1 to 0) edge. Suppose a pin changes just after a rising clock edge. Its `ext_pend` bit is still 0 after two rising clock edges and is 1 after the third. A change in the opposite direction sets nothing.
- R3: A pending flag stays set after the pin returns to its idle level. It is cleared only by an `ack` that grants that external source, and a grant to another source leaves it set.
- R4: Internal flags are level requests, and `ack` does not clear them. An internal flag that is still asserted requests again once its service has ended.
- R5: A maskable source with its `src_en` bit at 0, or any maskable source while `glob_en` is 0, produces no request. Power-fail (index 0) is masked only by `pf_en` and ignores `glob_en`.
- R6: Among eligible requests, power-fail beats every high-level request, and a high-level request (`src_hi` bit 1) beats every low-level request.
- R7: Among eligible requests at the same level, the lowest source index wins.
- R8: When `ack` arrives while `irq_valid` is 1, the winning level is recorded as in service. While a level is in service, requests at that level or below are not presented, and requests at a higher level are presented.
- R9: A `reti` pulse clears only the highest level in service, and lower levels stay in service.
- R10: The watchdog request is source 12. It is gated by its own enable bit `src_en[11]` and is arbitrated like any other internal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 6 | External interrupt pins, asynchronous |
| int_flag | input | 6 | Internal level request flags; bit 5 is the watchdog |
| pf_req | input | 1 | Power-fail request |
| pf_en | input | 1 | Power-fail enable |
| glob_en | input | 1 | Global enable for all maskable sources |
| src_en | input | 12 | Per-source enables; bit j belongs to source j+1 |
| src_hi | input | 12 | Per-source high-priority select; bit j belongs to source j+1 |
| ack | input | 1 | One-cycle acknowledge of the presented interrupt |
| reti | input | 1 | One-cycle return-from-interrupt pulse |
| irq_valid | output | 1 | An eligible request is presented |
| irq_vec | output | 4 | Index of the winning source |
| in_svc_lo | output | 1 | Low level in service |
| in_svc_hi | output | 1 | High level in service |
| in_svc_pf | output | 1 | Power-fail level in service |
| ext_pend | output | 6 | Pending flags of the external pins |

## Verification
Each pin is driven in both directions, and the latency of the synchronizer is checked. This separates the rising-edge pins from the falling-edge pins and shows that level alone sets nothing. Pairs of competing requests are tried in three ways: at the same level, split across the high and low levels, and against power-fail. These separate the index precedence from the level ranking. A nesting sequence goes through low, high and power-fail service and then unwinds with `reti`. It shows which requests are held back at each depth and that only the top level is released. Masking patterns switch the per-source enables and the global enable separately, which shows that power-fail escapes only the global mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_NUM_EXT = 6;
  localparam int unsigned IRQ_NUM_INT = 6;
  // service levels, ordered
  localparam logic [1:0] LVL_LO = 2'd0;
  localparam logic [1:0] LVL_HI = 2'd1;
  localparam logic [1:0] LVL_PF = 2'd2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  localparam logic IDLE = RISE ? 1'b0 : 1'b1;

  logic s1_q, s2_q, s3_q, pend_q;
  logic edge_hit, pend_d;

  always_comb begin
    edge_hit = RISE ? (s2_q & ~s3_q) : (~s2_q & s3_q);
    pend_d   = edge_hit | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      s3_q   <= IDLE;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned VEC_W   = 4
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] hi,
  input  logic [1:0]         cur_lvl,
  output logic               valid,
  output logic [VEC_W-1:0]   vec,
  output logic [1:0]         win_lvl
);
  import irq_pkg::*;

  function automatic logic [1:0] lvl_of(int idx, logic hi_bit);
    if (idx == 0) return LVL_PF;
    return hi_bit ? LVL_HI : LVL_LO;
  endfunction

  always_comb begin
    valid   = 1'b0;
    vec     = '0;
    win_lvl = LVL_LO;
    for (int l = 0; l < 3; l++) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (req[i] && (lvl_of(i, hi[i]) == 2'(l)) && ((3'(l) + 3'd1) > {1'b0, cur_lvl})) begin
          valid   = 1'b1;
          vec     = VEC_W'(i);
          win_lvl = 2'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_EXT  = irq_pkg::IRQ_NUM_EXT,
  parameter int unsigned NUM_INT  = irq_pkg::IRQ_NUM_INT,
  parameter logic [5:0]  EXT_RISE = 6'b010100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EXT-1:0]         ext_pin,
  input  logic [NUM_INT-1:0]         int_flag,
  input  logic                       pf_req,
  input  logic                       pf_en,
  input  logic                       glob_en,
  input  logic [NUM_EXT+NUM_INT-1:0] src_en,
  input  logic [NUM_EXT+NUM_INT-1:0] src_hi,
  input  logic                       ack,
  input  logic                       reti,
  output logic                       irq_valid,
  output logic [$clog2(1+NUM_EXT+NUM_INT)-1:0] irq_vec,
  output logic                       in_svc_lo,
  output logic                       in_svc_hi,
  output logic                       in_svc_pf,
  output logic [NUM_EXT-1:0]         ext_pend
);
  localparam int unsigned NUM_SRC = 1 + NUM_EXT + NUM_INT;
  localparam int unsigned VEC_W   = $clog2(NUM_SRC);

  logic [NUM_EXT-1:0] ext_clr;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] hi_sel;
  logic [2:0]         svc_q, svc_d;
  logic [1:0]         cur_lvl;
  logic [1:0]         win_lvl;
  logic               take;

  assign take = ack && irq_valid;

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : g_ext
      irq_edge_sync #(.RISE(EXT_RISE[g])) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin[g]),
        .clr  (ext_clr[g]),
        .pend (ext_pend[g])
      );
      assign ext_clr[g]  = take && (irq_vec == VEC_W'(g + 1));
      assign req[g + 1]  = glob_en && src_en[g] && ext_pend[g];
    end
    for (g = 0; g < NUM_INT; g++) begin : g_int
      assign req[NUM_EXT + 1 + g] = glob_en && src_en[NUM_EXT + g] && int_flag[g];
    end
  endgenerate

  assign req[0] = pf_req && pf_en;
  assign hi_sel = {src_hi, 1'b0};

  always_comb begin
    if (svc_q[2])      cur_lvl = 2'd3;
    else if (svc_q[1]) cur_lvl = 2'd2;
    else if (svc_q[0]) cur_lvl = 2'd1;
    else               cur_lvl = 2'd0;
  end

  irq_resolve #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_resolve (
    .req    (req),
    .hi     (hi_sel),
    .cur_lvl(cur_lvl),
    .valid  (irq_valid),
    .vec    (irq_vec),
    .win_lvl(win_lvl)
  );

  always_comb begin
    svc_d = svc_q;
    if (reti) begin
      if (svc_q[2])      svc_d[2] = 1'b0;
      else if (svc_q[1]) svc_d[1] = 1'b0;
      else               svc_d[0] = 1'b0;
    end
    if (take) svc_d[win_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 3'b000;
    else        svc_q <= svc_d;
  end

  assign in_svc_lo = svc_q[0];
  assign in_svc_hi = svc_q[1];
  assign in_svc_pf = svc_q[2];

  // R8
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> svc_q[$past(win_lvl)]);

  // R5
  glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && irq_valid) |-> (irq_vec == '0));

  // R5
  pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec == '0) |-> (pf_req && pf_en));

  // R9
  reti_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && svc_q != 3'b000) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ext_pin;
  logic [5:0]  int_flag;
  logic        pf_req, pf_en, glob_en;
  logic [11:0] src_en, src_hi;
  logic        ack, reti;
  logic        irq_valid;
  logic [3:0]  irq_vec;
  logic        in_svc_lo, in_svc_hi, in_svc_pf;
  logic [5:0]  ext_pend;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_flag(int_flag),
    .pf_req(pf_req), .pf_en(pf_en), .glob_en(glob_en), .src_en(src_en),
    .src_hi(src_hi), .ack(ack), .reti(reti), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .in_svc_lo(in_svc_lo), .in_svc_hi(in_svc_hi),
    .in_svc_pf(in_svc_pf), .ext_pend(ext_pend)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_pin = 6'b101011; int_flag = '0;
    pf_req = 0; pf_en = 0; glob_en = 0; src_en = '0; src_hi = '0;
    ack = 0; reti = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_ack();  ack = 1;  cyc(1); ack = 0;  cyc(1); endtask
  task automatic pulse_reti(); reti = 1; cyc(1); reti = 0; cyc(1); endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 svc", {in_svc_pf, in_svc_hi, in_svc_lo}, 0);
    chk("R1 pend", ext_pend, 0);
  endtask

  task automatic t_edges();
    do_reset();
    ext_pin[2] = 1'b1;
    cyc(2);
    chk("R2 latency", ext_pend[2], 0);
    cyc(1);
    chk("R2 rise pin2", ext_pend[2], 1);
    ext_pin[3] = 1'b0;
    cyc(3);
    chk("R2 fall pin3", ext_pend, 6'b001100);
    ext_pin[2] = 1'b0; ext_pin[4] = 1'b1; ext_pin[3] = 1'b1;
    cyc(1); ext_pin[4] = 1'b0;
    cyc(4);
    chk("R2 wrong direction / R3 sticky", ext_pend, 6'b011100);
  endtask

  task automatic t_ack_ext();
    do_reset();
    glob_en = 1; src_en[2] = 1; src_en[4] = 1;
    ext_pin[2] = 1; ext_pin[4] = 1;
    cyc(4);
    chk("R7 ext vec", irq_vec, 3);
    pulse_ack();
    chk("R3 ack clears pin2", ext_pend, 6'b010000);
    chk("R8 lo in svc", in_svc_lo, 1);
    chk("R8 same level held", irq_valid, 0);
  endtask

  task automatic t_int_level();
    do_reset();
    glob_en = 1; src_en[6] = 1; int_flag[0] = 1;
    cyc(1);
    chk("R4 int vec", irq_vec, 7);
    pulse_ack();
    chk("R4 blocked in svc", irq_valid, 0);
    pulse_reti();
    chk("R4 rerequest valid", irq_valid, 1);
    chk("R4 rerequest vec", irq_vec, 7);
  endtask

  task automatic t_prec();
    do_reset();
    glob_en = 1; src_en[6] = 1; src_en[9] = 1;
    int_flag[0] = 1; int_flag[3] = 1;
    cyc(1);
    chk("R7 lowest index", irq_vec, 7);
    src_hi[9] = 1;
    cyc(1);
    chk("R6 hi beats lo", irq_vec, 10);
    pf_en = 1; pf_req = 1;
    cyc(1);
    chk("R6 pf beats hi", irq_vec, 0);
  endtask

  task automatic t_mask();
    do_reset();
    int_flag = 6'b000011;
    glob_en = 1;
    cyc(1);
    chk("R5 src_en off", irq_valid, 0);
    src_en[6] = 1; glob_en = 0;
    cyc(1);
    chk("R5 glob_en off", irq_valid, 0);
    pf_req = 1; pf_en = 1;
    cyc(1);
    chk("R5 pf ignores glob", irq_vec, 0);
    chk("R5 pf valid", irq_valid, 1);
    pf_en = 0;
    cyc(1);
    chk("R5 pf_en off", irq_valid, 0);
  endtask

  task automatic t_nest();
    do_reset();
    glob_en = 1; src_en[6] = 1; src_en[7] = 1; src_en[9] = 1;
    int_flag[0] = 1;
    cyc(1);
    pulse_ack();
    int_flag[1] = 1;
    cyc(1);
    chk("R8 lo blocks lo", irq_valid, 0);
    src_hi[9] = 1; int_flag[3] = 1;
    cyc(1);
    chk("R8 hi preempts lo", irq_vec, 10);
    pulse_ack();
    chk("R8 hi in svc", in_svc_hi, 1);
    pf_en = 1; pf_req = 1;
    cyc(1);
    chk("R8 pf preempts hi", irq_vec, 0);
    pulse_ack();
    chk("R8 pf in svc", in_svc_pf, 1);
    pf_req = 0;
    pulse_reti();
    chk("R9 pf released only", {in_svc_pf, in_svc_hi, in_svc_lo}, 3'b011);
    chk("R9 hi still blocked", irq_valid, 0);
    pulse_reti();
    chk("R9 hi released", {in_svc_pf, in_svc_hi, in_svc_lo}, 3'b001);
    chk("R9 hi request back", irq_vec, 10);
  endtask

  task automatic t_wdog();
    do_reset();
    glob_en = 1; int_flag[5] = 1;
    cyc(1);
    chk("R10 wdog disabled", irq_valid, 0);
    src_en[11] = 1;
    cyc(1);
    chk("R10 wdog vec", irq_vec, 12);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_ack_ext();
    t_int_level();
    t_prec();
    t_mask();
    t_nest();
    t_wdog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule